// File: doc/BRIEF.md
# Three-Slot Pulse-Width/Amplitude Symbol Decoder

This block rebuilds a 4-bit word from one line symbol that carries data both in pulse width and in pulse amplitude over three equal time slots. An upstream sampler quantises the line once near the centre of each slot. For each slot it presents a sign bit, a "beyond reference" magnitude bit and the index of the slot, as given by a recovered symbol clock whose rising edge opens slot 1. The decoder collects the three samples of one symbol and emits the nibble with a single-cycle valid strobe.

Each slot has its own decode rule. The width bit comes only from the polarity of the middle slot. The first slot is expected positive and the last negative, so their magnitude tests carry one bit each. The middle slot gives a magnitude bit whatever its sign. A symbol whose outer slots show the wrong polarity is still decoded, but it is flagged as a code violation. If the slot index sequence breaks, the partial symbol is dropped and the decoder waits for the next slot 1.

Top module: `pwam_symbol_decoder`

## Requirements
- R1: During and right after synchronous reset, `nib_valid`, `nib` and `code_viol` are all 0.
- R2: `nib[3]` equals the sign bit of the accepted slot 2 sample (1 = positive).
- R3: `nib[2]` is 1 only when the slot 1 sample is positive and its magnitude bit is 1.
- R4: `nib[0]` is 1 only when the slot 3 sample is negative (sign 0) and its magnitude bit is 1.
- R5: `nib[1]` equals the magnitude bit of the slot 2 sample, whatever its sign.
- R6: `nib_valid` is high for exactly one cycle: the cycle after the clock edge that accepts a slot 3 sample completing the 1,2,3 sequence. `nib` and `code_viol` keep their values until the next such pulse.
- R7: `code_viol` is 1 with the pulse when slot 1 was negative or slot 3 was positive, and 0 otherwise. The nibble is still produced under the rules of R2 to R5.
- R8: A sample with `smp_valid` high whose slot index (1, 2 or 3 on `smp_slot`; 0 is illegal) does not follow the sequence discards the partial symbol. A slot 1 sample always starts a new symbol.
- R9: Cycles with `smp_valid` low are ignored, so idle cycles may separate the slots of a symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A slot sample is present this cycle |
| smp_slot | input | 2 | Slot index of the sample: 1, 2 or 3 |
| smp_sign | input | 1 | Sample polarity, 1 = positive |
| smp_big | input | 1 | Sample magnitude is beyond the reference |
| nib_valid | output | 1 | One-cycle strobe for a decoded symbol |
| nib | output | 4 | Decoded word, bit 3 = width bit |
| code_viol | output | 1 | Decoded symbol broke the polarity rules |

## Verification
On every cycle the checker confirms that the strobe never lasts two cycles and follows only a slot 3 sample. It also confirms that the outputs stay frozen between strobes, and that bit 0 and the violation flag agree with the slot 3 sample just accepted. Rules that span a whole symbol can only be shown by the bench's scenarios. These are the decoding of bits 1 to 3 from earlier slots, the discard and resynchronisation after a broken index sequence, and tolerance of idle gaps. The bench sweeps all sixteen legal words and every sign/magnitude combination of the three slots.

// File: rtl/pwam_dec_pkg.sv
package pwam_dec_pkg;

    localparam int NSLOTS  = 3;
    localparam int SLOT_W  = $clog2(NSLOTS + 1);
    localparam int NIB_W   = 4;

    typedef struct packed {
        logic sign;
        logic big;
    } slot_smp_t;

    typedef enum logic [1:0] {
        WAIT_S1 = 2'd0,
        WANT_S2 = 2'd1,
        WANT_S3 = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             viol;
    } dec_word_t;

    // Outer slots: fixed expected polarity, magnitude carries the bit.
    function automatic logic pos_big(input slot_smp_t s);
        return s.sign & s.big;
    endfunction

    function automatic logic neg_big(input slot_smp_t s);
        return ~s.sign & s.big;
    endfunction

    function automatic dec_word_t decode_symbol(input slot_smp_t s1,
                                                input slot_smp_t s2,
                                                input slot_smp_t s3);
        dec_word_t w;
        w.nib[3] = s2.sign;
        w.nib[2] = pos_big(s1);
        w.nib[1] = s2.big;
        w.nib[0] = neg_big(s3);
        w.viol   = ~s1.sign | s3.sign;
        return w;
    endfunction

endpackage

// File: rtl/slot_seq_tracker.sv
module slot_seq_tracker
    import pwam_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SLOT_W-1:0] smp_slot,
    output logic              take_s1,
    output logic              take_s2,
    output logic              take_s3
);
    seq_state_t state_q, state_d;

    always_comb begin
        take_s1 = smp_valid && (smp_slot == SLOT_W'(1));
        take_s2 = smp_valid && (smp_slot == SLOT_W'(2)) && (state_q == WANT_S2);
        take_s3 = smp_valid && (smp_slot == SLOT_W'(3)) && (state_q == WANT_S3);
    end

    always_comb begin
        state_d = state_q;
        if (smp_valid) begin
            if (take_s1)      state_d = WANT_S2;
            else if (take_s2) state_d = WANT_S3;
            else              state_d = WAIT_S1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WAIT_S1;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/slot_sample_store.sv
module slot_sample_store
    import pwam_dec_pkg::*;
#(
    parameter int KEEP = NSLOTS - 1
) (
    input  logic      clk,
    input  logic      rst,
    input  slot_smp_t smp_in,
    input  logic [KEEP-1:0] take,
    output slot_smp_t held [KEEP]
);
    for (genvar g = 0; g < KEEP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)          held[g] <= '0;
            else if (take[g]) held[g] <= smp_in;
        end
    end
endmodule

// File: rtl/nibble_former.sv
module nibble_former
    import pwam_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  slot_smp_t        s1,
    input  slot_smp_t        s2,
    input  slot_smp_t        s3,
    output logic             out_valid,
    output logic [NIB_W-1:0] out_nib,
    output logic             out_viol
);
    dec_word_t word_d, word_q;

    always_comb word_d = decode_symbol(s1, s2, s3);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word_q    <= '0;
        end else begin
            out_valid <= fire;
            if (fire) word_q <= word_d;
        end
    end

    assign out_nib  = word_q.nib;
    assign out_viol = word_q.viol;
endmodule

// File: rtl/pwam_symbol_decoder.sv
module pwam_symbol_decoder
    import pwam_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SLOT_W-1:0] smp_slot,
    input  logic              smp_sign,
    input  logic              smp_big,
    output logic              nib_valid,
    output logic [NIB_W-1:0]  nib,
    output logic              code_viol
);
    slot_smp_t cur;
    slot_smp_t held [NSLOTS-1];
    logic take_s1, take_s2, take_s3;

    assign cur = '{sign: smp_sign, big: smp_big};

    slot_seq_tracker u_seq (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_slot  (smp_slot),
        .take_s1   (take_s1),
        .take_s2   (take_s2),
        .take_s3   (take_s3)
    );

    slot_sample_store #(.KEEP(NSLOTS - 1)) u_store (
        .clk    (clk),
        .rst    (rst),
        .smp_in (cur),
        .take   ({take_s2, take_s1}),
        .held   (held)
    );

    nibble_former u_form (
        .clk       (clk),
        .rst       (rst),
        .fire      (take_s3),
        .s1        (held[0]),
        .s2        (held[1]),
        .s3        (cur),
        .out_valid (nib_valid),
        .out_nib   (nib),
        .out_viol  (code_viol)
    );
endmodule

// File: rtl/pwam_decoder_checks.sv
module pwam_decoder_checks
    import pwam_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [SLOT_W-1:0] smp_slot,
    input logic              smp_sign,
    input logic              smp_big,
    input logic              nib_valid,
    input logic [NIB_W-1:0]  nib,
    input logic              code_viol
);
    p_one_cycle_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        nib_valid |=> !nib_valid);

    p_strobe_after_slot3_r6: assert property (@(posedge clk) disable iff (rst)
        nib_valid |-> $past(smp_valid && smp_slot == SLOT_W'(3)));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
        !nib_valid |-> ($stable(nib) && $stable(code_viol)));

    p_bit0_from_slot3_r4: assert property (@(posedge clk) disable iff (rst)
        nib_valid |-> (nib[0] == $past(!smp_sign && smp_big)));

    p_viol_on_pos_slot3_r7: assert property (@(posedge clk) disable iff (rst)
        (nib_valid && $past(smp_sign)) |-> code_viol);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!nib_valid && nib == '0 && !code_viol));
endmodule

bind pwam_symbol_decoder pwam_decoder_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_slot  (smp_slot),
    .smp_sign  (smp_sign),
    .smp_big   (smp_big),
    .nib_valid (nib_valid),
    .nib       (nib),
    .code_viol (code_viol)
);

// File: tb/tb_pwam_symbol_decoder.sv
`timescale 1ns/1ps
module tb_pwam_symbol_decoder;
    localparam real HALF = 2.5;

    logic       clk = 0;
    logic       rst = 1;
    logic       smp_valid = 0;
    logic [1:0] smp_slot = 0;
    logic       smp_sign = 0;
    logic       smp_big = 0;
    logic       nib_valid;
    logic [3:0] nib;
    logic       code_viol;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    pwam_symbol_decoder dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_slot(smp_slot),
        .smp_sign(smp_sign), .smp_big(smp_big),
        .nib_valid(nib_valid), .nib(nib), .code_viol(code_viol)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] model(input logic a1s, a1b, a2s, a2b, a3s, a3b);
        logic [3:0] n;
        n = {a2s, a1s & a1b, a2b, ~a3s & a3b};
        return {n, ~a1s | a3s};
    endfunction

    // Present one sample for one clock, then sample outputs 1 ns after the edge.
    task automatic send(input logic [1:0] sl, input logic sg, input logic bg);
        @(negedge clk);
        smp_valid = 1; smp_slot = sl; smp_sign = sg; smp_big = bg;
        @(posedge clk); #1;
        smp_valid = 0; smp_slot = 2'd0; smp_sign = 0; smp_big = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 0; smp_slot = 2'(i); smp_sign = i[0]; smp_big = ~i[0];
            @(posedge clk); #1;
        end
    endtask

    task automatic symbol_and_check(input logic a1s, a1b, a2s, a2b, a3s, a3b,
                                    input string tag);
        logic [4:0] e;
        e = model(a1s, a1b, a2s, a2b, a3s, a3b);
        send(2'd1, a1s, a1b);
        check({tag, " R6 no strobe after slot1"}, nib_valid, 0);
        send(2'd2, a2s, a2b);
        send(2'd3, a3s, a3b);
        check({tag, " R6 strobe"}, nib_valid, 1);
        check({tag, " R2 bit3"}, nib[3], e[4]);
        check({tag, " R3 bit2"}, nib[2], e[3]);
        check({tag, " R5 bit1"}, nib[1], e[2]);
        check({tag, " R4 bit0"}, nib[0], e[1]);
        check({tag, " R7 viol"}, code_viol, e[0]);
        idle(1);
        check({tag, " R6 strobe drops"}, nib_valid, 0);
        check({tag, " R6 nib held"}, nib, int'(e[4:1]));
    endtask

    task automatic t_reset;
        check("R1 valid in reset", nib_valid, 0);
        check("R1 nib in reset", nib, 0);
        check("R1 viol in reset", code_viol, 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check("R1 valid after reset", nib_valid, 0);
        check("R1 nib after reset", nib, 0);
    endtask

    task automatic t_legal_words;
        for (int w = 0; w < 16; w++)
            symbol_and_check(1'b1, w[2], w[3], w[1], 1'b0, w[0], "legal");
    endtask

    task automatic t_all_polarities;
        for (int c = 0; c < 64; c++)
            symbol_and_check(c[5], c[4], c[3], c[2], c[1], c[0], "sweep");
    endtask

    task automatic t_gaps;
        send(2'd1, 1, 1);
        idle(3);
        check("R9 no strobe in gap", nib_valid, 0);
        send(2'd2, 0, 1);
        idle(2);
        send(2'd3, 0, 0);
        check("R9 strobe after gaps", nib_valid, 1);
        check("R9 nib after gaps", nib, 4'b0110);
        check("R9 viol after gaps", code_viol, 0);
        idle(1);
    endtask

    task automatic t_resync;
        // slot1 then slot3: skip
        send(2'd1, 1, 1); send(2'd3, 0, 1);
        check("R8 skip gives no strobe", nib_valid, 0);
        // repeated slot2
        send(2'd1, 1, 1); send(2'd2, 1, 1); send(2'd2, 1, 1); send(2'd3, 0, 1);
        check("R8 repeat gives no strobe", nib_valid, 0);
        // illegal index 0 mid symbol
        send(2'd1, 1, 1); send(2'd0, 1, 1); send(2'd2, 1, 1); send(2'd3, 0, 1);
        check("R8 index 0 gives no strobe", nib_valid, 0);
        check("R8 nib unchanged by discard", nib, 4'b0110);
        // restart on new slot1 mid symbol
        send(2'd1, 1, 1); send(2'd2, 1, 1);
        send(2'd1, 1, 0); send(2'd2, 0, 0); send(2'd3, 0, 1);
        check("R8 resync strobe", nib_valid, 1);
        check("R8 resync nib uses second symbol", nib, 4'b0001);
        idle(1);
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_legal_words();
        t_all_polarities();
        t_gaps();
        t_resync();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule